// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block keeps a small set of recently used virtual-to-physical page translations and answers lookups against all of them at once. A lookup presents a virtual address and says whether the access is a read or a write. The upper bits of the address are the virtual page number. They are compared against the tag of every valid entry in parallel. When one entry matches, the entry's permission bits are checked against the access type. If the access is allowed, the block returns the stored physical page number with the page offset appended unchanged. If no entry matches, the block reports a miss so that the page table in main memory can supply the translation. A refill then writes that translation into the buffer.

Lookups arrive on a valid/ready channel. A request is taken in any cycle where `lk_valid` and `lk_ready` are both high. `lk_ready` drops only in a cycle where `flush` is high, and a requester holds its request until it sees ready. The result appears on the next clock edge with `res_valid`. The result path has no back-pressure: the consumer takes each result in the cycle it is presented. Refill and flush are plain control inputs. A flush clears every entry when the running process changes.

Top module: `xlat_buffer`

## Requirements
- R1: After reset every entry is invalid, `res_valid` is low, and the first lookup misses.
- R2: A lookup is accepted when `lk_valid` and `lk_ready` are both high. `lk_ready` equals the inverse of `flush`. An accepted lookup produces `res_valid` high for exactly one cycle, on the edge after acceptance. In every other cycle `res_valid` is low.
- R3: The virtual page number is `lk_vaddr[42:13]` and the offset is `lk_vaddr[12:0]`. On an allowed hit, `res_hit` is 1 and `res_paddr` is the entry's 21-bit physical page number in bits 33:13 with the offset copied into bits 12:0.
- R4: When no valid entry holds the lookup's page number, `res_miss` is 1 and `res_paddr` is 0.
- R5: A matching entry with its write-enable bit clear raises `res_viol` on a write (`lk_write`=1). A matching entry with its read-enable bit clear raises `res_viol` on a read (`lk_write`=0). In either case `res_hit` is 0 and `res_paddr` is 0.
- R6: While `res_valid` is high, exactly one of `res_hit`, `res_miss` and `res_viol` is 1. While `res_valid` is low, all three are 0 and `res_paddr` is 0.
- R7: A refill picks its slot in this order: first the entry that already holds the same page number, which is overwritten; otherwise the lowest-numbered invalid entry; otherwise the entry at a rotating pointer. The pointer starts at 0, advances by one (modulo 32) on every accepted refill, and returns to 0 on flush.
- R8: A flush invalidates all entries in one cycle. A refill in the same cycle is ignored.
- R9: A lookup and a refill in the same cycle: the lookup sees the contents from before the refill.
- R10: All 32 entries can hold translations at once, and each of them can produce a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Invalidate every entry (process switch) |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_vaddr | input | 43 | Virtual address of the lookup |
| lk_write | input | 1 | 1 for a write access, 0 for a read |
| fill_en | input | 1 | Write one translation into the buffer |
| fill_vpn | input | 30 | Virtual page number of the refill |
| fill_ppn | input | 21 | Physical page number of the refill |
| fill_rd | input | 1 | Read-enable bit of the refill |
| fill_wr | input | 1 | Write-enable bit of the refill |
| res_valid | output | 1 | Result valid, one cycle after acceptance |
| res_hit | output | 1 | Allowed hit |
| res_miss | output | 1 | No matching entry |
| res_viol | output | 1 | Matching entry forbids this access |
| res_paddr | output | 34 | Physical address on a hit, otherwise 0 |

## Verification
The hardest state to reach from the ports is a full buffer in which replacement falls to the rotating pointer. Reaching it also requires the pointer position to be known. The stimulus first flushes the buffer so the pointer is back at 0. It then refills all 32 entries with distinct page numbers, which drives the pointer once around the ring. After that it issues further refills and lookups, and these show which entry was evicted. It also overwrites a page number already in the buffer, and checks that the replacement did not create a second copy. A random phase then draws page numbers from a pool small enough to force repeated matches and overwrites. That phase also mixes in flushes and same-cycle refill/lookup pairs, and every cycle is compared against a behavioural model.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef struct packed {
    logic rd;
    logic wr;
  } xlat_perm_t;

  // An access is allowed when the permission matching its direction is set.
  function automatic logic xlat_allowed(input xlat_perm_t perm, input logic is_write);
    return is_write ? perm.wr : perm.rd;
  endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 30
) (
  input  logic [ENTRIES-1:0]            valid_q,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tag_q,
  input  logic [VPN_W-1:0]              key,
  output logic [ENTRIES-1:0]            match_vec,
  output logic                          any_match
);

  // One comparator per entry, all evaluated in parallel.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_q[g] && (tag_q[g] == key);
  end

  assign any_match = |match_vec;

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_q,
  input  logic               dup_hit,
  input  logic [ENTRIES-1:0] dup_vec,
  input  logic [IDX_W-1:0]   ptr_q,
  output logic [IDX_W-1:0]   slot
);

  logic [IDX_W-1:0] dup_idx;
  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  always_comb begin
    dup_idx    = '0;
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (dup_vec[i]) dup_idx = IDX_W'(i);
    end
    // Scan downwards so the lowest invalid index wins.
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
    if (dup_hit)         slot = dup_idx;
    else if (free_found) slot = free_idx;
    else                 slot = ptr_q;
  end

endmodule

// File: rtl/xlat_resp.sv
module xlat_resp
  import xlat_pkg::*;
#(
  parameter int PPN_W = 21,
  parameter int OFF_W = 13,
  parameter int PA_W  = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             is_write,
  input  logic             found,
  input  xlat_perm_t       perm,
  input  logic [PPN_W-1:0] ppn,
  input  logic [OFF_W-1:0] offset,
  output logic             res_valid,
  output logic             res_hit,
  output logic             res_miss,
  output logic             res_viol,
  output logic [PA_W-1:0]  res_paddr
);

  logic violation;
  logic granted;

  assign violation = found && !xlat_allowed(perm, is_write);
  assign granted   = accept && found && !violation;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_viol  <= 1'b0;
      res_paddr <= '0;
    end else begin
      res_valid <= accept;
      res_hit   <= granted;
      res_miss  <= accept && !found;
      res_viol  <= accept && violation;
      res_paddr <= granted ? {ppn, offset} : '0;
    end
  end

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 30,
  parameter int PPN_W   = 21,
  parameter int OFF_W   = 13,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_write,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_rd,
  input  logic             fill_wr,
  output logic             res_valid,
  output logic             res_hit,
  output logic             res_miss,
  output logic             res_viol,
  output logic [PA_W-1:0]  res_paddr
);

  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  xlat_perm_t [ENTRIES-1:0]      perm_q;
  logic [IDX_W-1:0]              ptr_q;

  logic [ENTRIES-1:0] lk_match;
  logic               lk_found;
  logic [ENTRIES-1:0] fill_match;
  logic               fill_found;
  logic [IDX_W-1:0]   fill_slot;
  logic [PPN_W-1:0]   hit_ppn;
  xlat_perm_t         hit_perm;
  logic               accept;
  logic               fill_take;

  assign lk_ready  = !flush;
  assign accept    = lk_valid && lk_ready;
  assign fill_take = fill_en && !flush;

  // Lookup compare bank.
  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
    .valid_q   (valid_q),
    .tag_q     (tag_q),
    .key       (lk_vaddr[VA_W-1:OFF_W]),
    .match_vec (lk_match),
    .any_match (lk_found)
  );

  // Refill compare bank, keeps every page number in at most one entry.
  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill_match (
    .valid_q   (valid_q),
    .tag_q     (tag_q),
    .key       (fill_vpn),
    .match_vec (fill_match),
    .any_match (fill_found)
  );

  xlat_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid_q (valid_q),
    .dup_hit (fill_found),
    .dup_vec (fill_match),
    .ptr_q   (ptr_q),
    .slot    (fill_slot)
  );

  // Match vector is one-hot or empty, so an OR of masked entries selects.
  always_comb begin
    hit_ppn  = '0;
    hit_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        hit_ppn     = hit_ppn | ppn_q[i];
        hit_perm.rd = hit_perm.rd | perm_q[i].rd;
        hit_perm.wr = hit_perm.wr | perm_q[i].wr;
      end
    end
  end

  xlat_resp #(.PPN_W(PPN_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_resp (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .is_write  (lk_write),
    .found     (lk_found),
    .perm      (hit_perm),
    .ppn       (hit_ppn),
    .offset    (lk_vaddr[OFF_W-1:0]),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_miss  (res_miss),
    .res_viol  (res_viol),
    .res_paddr (res_paddr)
  );

  // Valid bits and the rotating pointer; flush outranks refill.
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (fill_take) begin
      valid_q[fill_slot] <= 1'b1;
      ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  // Entry payload needs no reset: it is ignored while the valid bit is low.
  always_ff @(posedge clk) begin
    if (fill_take) begin
      tag_q[fill_slot]  <= fill_vpn;
      ppn_q[fill_slot]  <= fill_ppn;
      perm_q[fill_slot] <= '{rd: fill_rd, wr: fill_wr};
    end
  end

endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk #(
  parameter int VA_W  = 43,
  parameter int PA_W  = 34,
  parameter int OFF_W = 13
) (
  input logic            clk,
  input logic            rst,
  input logic            flush,
  input logic            lk_valid,
  input logic            lk_ready,
  input logic [VA_W-1:0] lk_vaddr,
  input logic            res_valid,
  input logic            res_hit,
  input logic            res_miss,
  input logic            res_viol,
  input logic [PA_W-1:0] res_paddr
);

  // R2
  accept_gives_result_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_ready) |=> res_valid);

  // R2
  no_request_no_result_chk: assert property (@(posedge clk) disable iff (rst)
    !(lk_valid && lk_ready) |=> !res_valid);

  // R2
  flush_stalls_request_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> !lk_ready);

  // R6
  single_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($countones({res_hit, res_miss, res_viol}) == 1));

  // R6
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_hit && !res_miss && !res_viol && res_paddr == '0));

  // R3
  offset_passthrough_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_ready) |=>
      (!res_hit || res_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

  // R4 R5
  zero_addr_on_refusal_chk: assert property (@(posedge clk) disable iff (rst)
    (res_miss || res_viol) |-> (res_paddr == '0));

  // R8
  flush_then_miss_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(flush) && lk_valid && lk_ready) |=> res_miss);

endmodule

bind xlat_buffer xlat_buffer_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_xlat_chk (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .lk_valid  (lk_valid),
  .lk_ready  (lk_ready),
  .lk_vaddr  (lk_vaddr),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_miss  (res_miss),
  .res_viol  (res_viol),
  .res_paddr (res_paddr)
);

// File: tb/test_xlat_buffer.sv
`timescale 1ns/1ps
module test_xlat_buffer;

  localparam int N  = 32;
  localparam int VW = 30;
  localparam int PW = 21;
  localparam int OW = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flush = 1'b0;
  logic          lk_valid = 1'b0;
  logic          lk_ready;
  logic [VW+OW-1:0] lk_vaddr = '0;
  logic          lk_write = 1'b0;
  logic          fill_en = 1'b0;
  logic [VW-1:0] fill_vpn = '0;
  logic [PW-1:0] fill_ppn = '0;
  logic          fill_rd = 1'b0;
  logic          fill_wr = 1'b0;
  logic          res_valid, res_hit, res_miss, res_viol;
  logic [PW+OW-1:0] res_paddr;

  int total = 0;
  int fails = 0;

  // Behavioural reference state.
  bit            m_valid [N];
  bit [VW-1:0]   m_tag   [N];
  bit [PW-1:0]   m_ppn   [N];
  bit            m_rd    [N];
  bit            m_wr    [N];
  int            m_ptr = 0;

  always #4 clk = ~clk;

  xlat_buffer i_xlat_buffer (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr), .lk_write(lk_write),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_rd(fill_rd), .fill_wr(fill_wr),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
    .res_viol(res_viol), .res_paddr(res_paddr)
  );

  task automatic model_clear();
    for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
    m_ptr = 0;
  endtask

  task automatic model_update();
    int slot;
    if (flush) begin
      model_clear();
    end else if (fill_en) begin
      slot = -1;
      for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == fill_vpn) slot = i;
      if (slot < 0) for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) slot = i;
      if (slot < 0) slot = m_ptr;
      m_valid[slot] = 1'b1;
      m_tag[slot]   = fill_vpn;
      m_ppn[slot]   = fill_ppn;
      m_rd[slot]    = fill_rd;
      m_wr[slot]    = fill_wr;
      m_ptr = (m_ptr + 1) % N;
    end
  endtask

  // One clock: predict from the pre-edge model, advance, compare at the next negedge.
  task automatic step(input string tag);
    bit acc, found, ok, ev, eh, em, ex;
    bit [PW+OW-1:0] ep;
    int idx;
    #1;
    total++;
    if (lk_ready !== !flush) begin
      fails++;
      $display("FAIL R2 lk_ready: got %b expected %b", lk_ready, !flush);
    end
    acc = lk_valid && !flush;
    found = 1'b0; idx = 0;
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_tag[i] == lk_vaddr[VW+OW-1:OW]) begin found = 1'b1; idx = i; end
    ok = found && (lk_write ? m_wr[idx] : m_rd[idx]);
    ev = acc;
    eh = acc && ok;
    em = acc && !found;
    ex = acc && found && !ok;
    ep = eh ? {m_ppn[idx], lk_vaddr[OW-1:0]} : '0;
    @(posedge clk);
    model_update();
    @(negedge clk);
    total++;
    if (res_valid !== ev || res_hit !== eh || res_miss !== em || res_viol !== ex || res_paddr !== ep) begin
      fails++;
      $display("FAIL %s: got v%b h%b m%b x%b pa=%h, expected v%b h%b m%b x%b pa=%h",
               tag, res_valid, res_hit, res_miss, res_viol, res_paddr, ev, eh, em, ex, ep);
    end
  endtask

  task automatic quiet();
    flush = 0; lk_valid = 0; fill_en = 0; lk_write = 0;
  endtask

  task automatic lookup(input bit [VW-1:0] vpn, input bit [OW-1:0] off, input bit wr, input string tag);
    lk_valid = 1; lk_vaddr = {vpn, off}; lk_write = wr;
    step(tag);
    quiet();
  endtask

  task automatic fill(input bit [VW-1:0] vpn, input bit [PW-1:0] ppn, input bit rd, input bit wr, input string tag);
    fill_en = 1; fill_vpn = vpn; fill_ppn = ppn; fill_rd = rd; fill_wr = wr;
    step(tag);
    quiet();
  endtask

  initial begin
    #(200000 * 8);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    total++;
    if (res_valid !== 1'b0 || res_hit !== 1'b0 || res_miss !== 1'b0 || res_viol !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs: got v%b h%b m%b x%b expected all 0",
               res_valid, res_hit, res_miss, res_viol);
    end
    rst = 0;

    // R1: empty after reset
    lookup(30'h0000_1234, 13'h0ABC, 0, "R1");
    step("R2");

    // R3: plain hits with offset passthrough
    fill(30'h0000_0A01, 21'h1_2345, 1, 1, "R7");
    lookup(30'h0000_0A01, 13'h1FFF, 0, "R3");
    lookup(30'h0000_0A01, 13'h0001, 1, "R3");
    lookup(30'h0000_0A02, 13'h0001, 0, "R4");

    // R5: permission refusals
    fill(30'h0000_0B00, 21'h0_0F0F, 1, 0, "R7");
    lookup(30'h0000_0B00, 13'h0123, 1, "R5");
    lookup(30'h0000_0B00, 13'h0123, 0, "R3");
    fill(30'h3FFF_FFFF, 21'h1F_FFFF, 0, 1, "R7");
    lookup(30'h3FFF_FFFF, 13'h0040, 0, "R5");
    lookup(30'h3FFF_FFFF, 13'h0040, 1, "R3");

    // R9: same-cycle refill and lookup
    fill_en = 1; fill_vpn = 30'h0000_0D00; fill_ppn = 21'h0_0D0D; fill_rd = 1; fill_wr = 1;
    lk_valid = 1; lk_vaddr = {30'h0000_0D00, 13'h0007}; lk_write = 0;
    step("R9");
    quiet();
    lookup(30'h0000_0D00, 13'h0007, 0, "R9");

    // R8: flush with a refill and a request in the same cycle
    flush = 1; fill_en = 1; fill_vpn = 30'h0000_0E00; fill_ppn = 21'h0_0E0E; fill_rd = 1; fill_wr = 1;
    lk_valid = 1; lk_vaddr = {30'h0000_0A01, 13'h0}; lk_write = 0;
    step("R8");
    quiet();
    lookup(30'h0000_0A01, 13'h0, 0, "R8");
    lookup(30'h0000_0E00, 13'h0, 0, "R8");

    // R10: fill every entry, hit each one
    for (int i = 0; i < N; i++) fill(30'h0010_0000 + VW'(i), PW'(21'h0_4000 + i), 1, 1, "R10");
    for (int i = 0; i < N; i++) lookup(30'h0010_0000 + VW'(i), OW'(i * 37), 0, "R10");

    // R7: replacement by pointer and overwrite of an existing page number
    fill(30'h0020_0000, 21'h0_5000, 1, 1, "R7");
    lookup(30'h0010_0000, 13'h0, 0, "R7");
    lookup(30'h0020_0000, 13'h0055, 0, "R7");
    lookup(30'h0010_0001, 13'h0, 0, "R7");
    fill(30'h0020_0001, 21'h0_5001, 1, 1, "R7");
    lookup(30'h0010_0001, 13'h0, 0, "R7");
    fill(30'h0010_0005, 21'h1_AAAA, 1, 0, "R7");
    lookup(30'h0010_0005, 13'h0ACE, 0, "R7");
    lookup(30'h0010_0005, 13'h0ACE, 1, "R7");
    lookup(30'h0010_0002, 13'h0, 0, "R7");

    // R6: random mix over a small page pool
    for (int c = 0; c < 600; c++) begin
      flush    = ($urandom_range(0, 39) == 0);
      fill_en  = ($urandom_range(0, 3) == 0);
      fill_vpn = 30'h2AAA_0000 | VW'($urandom_range(0, 47));
      fill_ppn = PW'($urandom);
      fill_rd  = $urandom_range(0, 1);
      fill_wr  = $urandom_range(0, 1);
      lk_valid = $urandom_range(0, 1);
      lk_vaddr = {30'h2AAA_0000 | VW'($urandom_range(0, 47)), OW'($urandom)};
      lk_write = $urandom_range(0, 1);
      step("R6");
    end
    quiet();
    step("R2");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule